// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is a station-management master. It runs single Clause 22 read or write transactions to an external PHY over a two-wire management bus. The bus is a management clock, `mdc`, and a shared bidirectional data line. The data line is presented as a separate output value, an output enable and a sampled input.

Software talks to the block through an eight-entry, byte-wide register window:

- Entries 0 to 3 hold a 32-bit command word, lowest byte first.
- Entries 4 to 7 hold a 32-bit status word, in the same byte order.

Writing the top command byte with its go bit set launches one frame. Software then polls the go bit until it reads zero. After a read it takes the returned data and the failure flag from the status word.

The management clock is derived from the system clock by a parameterized divider. The master changes the data line after each falling edge of the management clock. It samples the PHY's answer on each rising edge. Timeouts, retries and arbitration between software agents are left to the software.

Top module: `mdio_master`

## Requirements
- R1: Window entries 0..3 hold command bits 7:0, 15:8, 23:16 and 31:24, and entries 4..7 hold status bits 7:0 through 31:24 in the same order. After reset every entry reads 0, and a command byte reads back what was last written to it, except for bit 31.
- R2: Command fields are:
  - bit 31: go;
  - bit 26: direction, 1 = write and 0 = read;
  - bits 25:21: the PHY address (0..31);
  - bits 20:16: the register address (0..31);
  - bits 15:0: the write data.
  A write transaction stores its data in the addressed PHY register.
- R3: Writing entry 3 with bit 7 set while idle starts a transaction. Command bit 31 then reads 1 for exactly 2*DIV_HALF*(PRE_LEN+32) system clocks and reads 0 afterwards.
- R4: Each frame is sent in this order:
  - PRE_LEN ones;
  - start bits 0,1;
  - opcode, 1,0 for a read or 0,1 for a write;
  - PHY address, MSB first;
  - register address, MSB first;
  - two turnaround bits, driven 1,0 on a write;
  - 16 data bits, MSB first.
- R5: `mdc` is low while idle and has a period of 2*DIV_HALF system clocks during a frame. The data line changes only after falling edges of `mdc`.
- R6: After a read completes, status bits 15:0 hold the 16 bits the PHY returned.
- R7: Status bit 31 is set when the data line is high at the second turnaround bit of a read. With no device present, the line is pulled up and the status word reads 0x8000FFFF.
- R8: Starting a transaction clears the status word to 0. A successful read that follows a failed one reports bit 31 as 0.
- R9: Writes to entries 0..3 while a transaction runs are ignored. They change neither the stored command nor the frame in flight.
- R10: During a read, the output enable is low from the first turnaround bit to the end of the frame.
- R11: Writing entry 3 with bit 7 clear stores the byte without starting a transaction, and `mdc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Window entry select (0..3 command, 4..7 status) |
| regWe | input | 1 | Write strobe for the selected entry |
| regWdata | input | 8 | Write data byte |
| regRdata | output | 8 | Read data byte of the selected entry (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Value driven on the data line |
| mdioOe | output | 1 | Output enable for the data line |
| mdioIn | input | 1 | Sampled level of the data line |

## Verification
The hardest situations to reach from the ports are the turnaround check and a register write that lands while a frame is in flight. Both depend on where the serializer stands in the 64-bit frame.

The bench attaches a PHY model that counts management-clock rising edges. The model drives the second turnaround bit low and returns data from its register array, but only at its own address. At every other address it leaves the pulled-up line alone. This exercises the failure path across a sweep of all 32 addresses.

A further test writes over every command byte, including one with the go bit set, while a write frame is running. It then confirms that the stored command and the PHY register written by the frame are both untouched.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  // Strobes issued by the control unit to the datapath, one clock wide each.
  typedef struct packed {
    logic shift;       // falling mdc edge: move to the next outgoing bit
    logic taSample;    // rising mdc edge on the second turnaround bit
    logic dataSample;  // rising mdc edge inside the data field
    logic done;        // falling mdc edge after the last bit
    logic turnPhase;   // bit counter is at or past the first turnaround bit
  } mdioStb_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  output logic     busy,
  output logic     mdc,
  output mdioStb_t stb
);
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int BIT_W     = $clog2(FRAME_LEN);
  localparam int DIV_W     = $clog2(DIV_HALF + 1);
  localparam logic [BIT_W-1:0] TURN_IDX = BIT_W'(PRE_LEN + 14);
  localparam logic [BIT_W-1:0] TA2_IDX  = BIT_W'(PRE_LEN + 15);
  localparam logic [BIT_W-1:0] DATA_IDX = BIT_W'(PRE_LEN + 16);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(FRAME_LEN - 1);
  localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(DIV_HALF - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic tick, riseEv, fallEv;

  assign tick   = busy && (divCnt == DIV_TOP);
  assign riseEv = tick && !mdc;
  assign fallEv = tick && mdc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (startReq) begin
      busy   <= 1'b1;
      mdc    <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdc    <= ~mdc;
        if (mdc) begin
          if (bitCnt == LAST_IDX) busy <= 1'b0;
          else bitCnt <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    stb.shift      = fallEv && (bitCnt != LAST_IDX);
    stb.done       = fallEv && (bitCnt == LAST_IDX);
    stb.taSample   = riseEv && (bitCnt == TA2_IDX);
    stb.dataSample = riseEv && (bitCnt >= DATA_IDX);
    stb.turnPhase  = (bitCnt >= TURN_IDX);
  end

  // R5
  idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);
  // R5
  mdc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick && !startReq) |=> $stable(mdc));
  // R3
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> !busy);
  // R3
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (busy && !mdc));
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  input  logic       busy,
  input  mdioStb_t   stb,
  input  logic       mdioIn,
  output logic       startReq,
  output logic       mdioOut,
  output logic       mdioOe
);
  localparam int FRAME_LEN = PRE_LEN + 32;

  logic [30:0]          cmdReg;   // bit 31 is reported from the control unit
  logic [FRAME_LEN-1:0] frameSr;
  logic [FRAME_LEN-1:0] newFrame;
  logic                 isRead;
  logic                 failFlag;
  logic [15:0]          rdData;
  logic                 cmdWrEn;
  logic                 wrSel;
  logic [31:0]          statusWord;
  logic [31:0]          cmdView;

  assign cmdWrEn  = regWe && !busy && !regAddr[2];
  assign startReq = cmdWrEn && (regAddr[1:0] == 2'd3) && regWdata[7];
  assign wrSel    = regWdata[2];

  // Command byte lanes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (cmdWrEn) begin
      case (regAddr[1:0])
        2'd0:    cmdReg[7:0]   <= regWdata;
        2'd1:    cmdReg[15:8]  <= regWdata;
        2'd2:    cmdReg[23:16] <= regWdata;
        default: cmdReg[30:24] <= regWdata[6:0];
      endcase
    end
  end

  // Frame image taken from the stored low bytes and the byte being written
  always_comb begin
    newFrame = {{PRE_LEN{1'b1}}, 2'b01,
                (wrSel ? 2'b01 : 2'b10),
                regWdata[1:0], cmdReg[23:16],
                (wrSel ? 2'b10 : 2'b11),
                cmdReg[15:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameSr <= '1;
      isRead  <= 1'b0;
    end else if (startReq) begin
      frameSr <= newFrame;
      isRead  <= !wrSel;
    end else if (stb.shift) begin
      frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
    end
  end

  // Status capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag <= 1'b0;
      rdData   <= '0;
    end else if (startReq) begin
      failFlag <= 1'b0;
      rdData   <= '0;
    end else if (isRead) begin
      if (stb.taSample)   failFlag <= mdioIn;
      if (stb.dataSample) rdData   <= {rdData[14:0], mdioIn};
    end
  end

  assign mdioOut = busy ? frameSr[FRAME_LEN-1] : 1'b1;
  assign mdioOe  = busy && !(isRead && stb.turnPhase);

  assign statusWord = {failFlag, 15'd0, rdData};
  assign cmdView    = {busy, cmdReg};

  always_comb begin
    case (regAddr)
      3'd0:    regRdata = cmdView[7:0];
      3'd1:    regRdata = cmdView[15:8];
      3'd2:    regRdata = cmdView[23:16];
      3'd3:    regRdata = cmdView[31:24];
      3'd4:    regRdata = statusWord[7:0];
      3'd5:    regRdata = statusWord[15:8];
      3'd6:    regRdata = statusWord[23:16];
      default: regRdata = statusWord[31:24];
    endcase
  end

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWe && !regAddr[2]) |=> $stable(cmdReg));
  // R10
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isRead && stb.turnPhase) |-> !mdioOe);
  // R8
  start_clears_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (statusWord == 32'd0));
  // R5
  mdio_change_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.shift && !stb.done) |=> $stable(mdioOut));
  // R7
  fail_only_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !isRead) |-> !failFlag);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int PRE_LEN  = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regAddr,
  input  logic       regWe,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       mdc,
  output logic       mdioOut,
  output logic       mdioOe,
  input  logic       mdioIn
);
  mdioStb_t stb;
  logic     busy;
  logic     startReq;

  mdio_ctrl #(.DIV_HALF(DIV_HALF), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .busy(busy), .mdc(mdc), .stb(stb)
  );

  mdio_datapath #(.PRE_LEN(PRE_LEN)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .stb(stb),
    .mdioIn(mdioIn), .startReq(startReq), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int DIV_HALF  = 2;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int BUSY_CYC  = 2 * DIV_HALF * FRAME_LEN;
  localparam int PHY_HERE  = 5;
  localparam time CLK_P    = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2.0) clk = ~clk;

  mdio_master #(.DIV_HALF(DIV_HALF), .PRE_LEN(PRE_LEN)) u_mdio_master (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  // ---------------- PHY model ----------------
  logic [15:0] phyRegs [32];
  logic phyDrive = 1'b0;
  logic phyOut = 1'b1;
  logic [FRAME_LEN-1:0] rx;
  logic [FRAME_LEN-1:0] lastFrame;
  logic [15:0] rdVal;
  int phyCnt = 0;
  bit oeBad, gapBad;
  time lastRise;

  assign mdioIn = phyDrive ? phyOut : (mdioOe ? mdioOut : 1'b1);

  always @(posedge mdc) begin
    int n;
    n = phyCnt;
    phyCnt++;
    rx = {rx[FRAME_LEN-2:0], mdioIn};
    if (n > 0 && ($time - lastRise) != 2 * DIV_HALF * CLK_P) gapBad = 1;
    lastRise = $time;
    if (n >= PRE_LEN + 14 && lastFrameRead() && mdioOe) oeBad = 1;
    if (n == PRE_LEN + 14) begin
      // opcode at rx[12:11], phy at rx[10:6], reg at rx[5:1]
      if (rx[12:11] == 2'b10 && rx[10:6] == 5'(PHY_HERE)) begin
        rdVal = phyRegs[rx[5:1]];
        #1 phyDrive = 1'b1; phyOut = 1'b0;
      end
    end else if (n >= PRE_LEN + 15 && n <= PRE_LEN + 30 && phyDrive) begin
      #1 phyOut = rdVal[PRE_LEN + 30 - n];
    end else if (n == FRAME_LEN - 1) begin
      lastFrame = rx;
      if (rx[29:28] == 2'b01 && rx[27:23] == 5'(PHY_HERE))
        phyRegs[rx[22:18]] = rx[15:0];
      #1 phyDrive = 1'b0;
    end
  end

  // rx opcode position before the frame ends (n >= PRE_LEN+14 -> bits at rx[12+k])
  function automatic bit lastFrameRead();
    int k;
    k = phyCnt - 1 - (PRE_LEN + 14);
    return rx[12 + k] == 1'b1 && rx[11 + k] == 1'b0;
  endfunction

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readWord(input logic [2:0] base, output logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      regAddr = base + 3'(b);
      #1 w[8*b +: 8] = regRdata;
    end
  endtask

  task automatic startCmd(input logic [31:0] cmd);
    regWrite(3'd0, cmd[7:0]);
    regWrite(3'd1, cmd[15:8]);
    regWrite(3'd2, cmd[23:16]);
    phyCnt = 0; oeBad = 0; gapBad = 0;
    regWrite(3'd3, cmd[31:24]);
  endtask

  task automatic waitDone(output int cyc);
    cyc = 0;
    regAddr = 3'd3;
    #1;
    while (regRdata[7]) begin
      cyc++;
      @(negedge clk);
      regAddr = 3'd3;
      #1;
    end
  endtask

  function automatic logic [31:0] mkCmd(bit wr, int phy, int rg, logic [15:0] d);
    return {1'b1, 4'd0, wr, 5'(phy), 5'(rg), d};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] w;
    int cyc;
    for (int i = 0; i < 32; i++) phyRegs[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readWord(3'd0, w); check(w == 0, "R1", "reset command", w, 0);
    readWord(3'd4, w); check(w == 0, "R1", "reset status", w, 0);
    check(!mdc && !mdioOe, "R5", "idle mdc/oe", {30'd0, mdc, mdioOe}, 0);

    // R11 byte3 without go; R1/R2 byte layout
    regWrite(3'd0, 8'h34); regWrite(3'd1, 8'h12);
    regWrite(3'd2, 8'hAB); regWrite(3'd3, 8'h04);
    repeat (20) @(negedge clk);
    check(!mdc, "R11", "mdc stays low", {31'd0, mdc}, 0);
    readWord(3'd0, w); check(w == 32'h04AB1234, "R11", "stored command", w, 32'h04AB1234);

    // Write sweep on the present PHY
    for (int i = 0; i < 32; i++) begin
      logic [15:0] v;
      logic [31:0] c;
      v = 16'h2468 + 16'(i * 16'h0F1D);
      c = mkCmd(1, PHY_HERE, i, v);
      startCmd(c);
      if (i == 0) begin
        regAddr = 3'd3; #1;
        check(regRdata[7] == 1'b1, "R3", "go reads 1 while running", {24'd0, regRdata}, 32'h80);
      end
      waitDone(cyc);
      if (i == 0) check(cyc == BUSY_CYC, "R3", "busy length", cyc, BUSY_CYC);
      check(lastFrame[63:32] == 32'hFFFFFFFF && lastFrame[31:30] == 2'b01 &&
            lastFrame[29:28] == 2'b01 && lastFrame[17:16] == 2'b10,
            "R4", "write frame framing", lastFrame[63:32], {lastFrame[31:30], lastFrame[29:28], lastFrame[17:16]});
      check(lastFrame[27:23] == 5'(PHY_HERE) && lastFrame[22:18] == 5'(i) && lastFrame[15:0] == v,
            "R2", "write frame fields", lastFrame[31:0], {14'd0, 5'(PHY_HERE), 5'(i), 8'd0});
      check(phyRegs[i] == v, "R2", "phy register written", phyRegs[i], v);
      check(!gapBad, "R5", "mdc period", 0, 0);
    end

    // Read sweep on the present PHY
    for (int i = 0; i < 32; i++) begin
      logic [15:0] v;
      v = 16'h2468 + 16'(i * 16'h0F1D);
      startCmd(mkCmd(0, PHY_HERE, i, 16'h0));
      waitDone(cyc);
      readWord(3'd4, w);
      check(w == {16'd0, v}, "R6", "read data", w, {16'd0, v});
      check(lastFrame[29:28] == 2'b10, "R4", "read opcode", lastFrame[29:28], 2'b10);
      check(!oeBad, "R10", "oe released in read", 1, 0);
      check(!gapBad, "R5", "mdc period in read", 1, 0);
    end

    // Address sweep: absent devices fail
    for (int a = 0; a < 32; a++) begin
      logic [31:0] e;
      e = (a == PHY_HERE) ? {16'd0, phyRegs[3]} : 32'h8000FFFF;
      startCmd(mkCmd(0, a, 3, 16'h0));
      waitDone(cyc);
      readWord(3'd4, w);
      check(w == e, "R7", "address sweep status", w, e);
    end

    // R8 clear on start after a failure (last sweep address 31 failed)
    startCmd(mkCmd(0, PHY_HERE, 1, 16'h0));
    readWord(3'd4, w);
    check(w == 0, "R8", "status cleared at start", w, 0);
    waitDone(cyc);
    readWord(3'd4, w);
    check(w == {16'd0, phyRegs[1]}, "R8", "fail clear after good read", w, {16'd0, phyRegs[1]});

    // R9 writes while busy are ignored
    begin
      logic [31:0] c;
      c = mkCmd(1, PHY_HERE, 7, 16'h1111);
      startCmd(c);
      regWrite(3'd0, 8'hEE); regWrite(3'd1, 8'hDD);
      regWrite(3'd2, 8'hCC); regWrite(3'd3, 8'hFF);
      waitDone(cyc);
      readWord(3'd0, w);
      check(w == {1'b0, c[30:0]}, "R9", "command untouched", w, {1'b0, c[30:0]});
      check(phyRegs[7] == 16'h1111, "R9", "frame in flight untouched", phyRegs[7], 16'h1111);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule